// File: doc/BRIEF.md
# Conversion Mode and Ready Sequencer

This block schedules conversions for a slow sigma-delta converter and owns its result register and the two status flags that go with it. It runs one of three operating modes. Continuous mode converts without pause and is active out of reset. Single-shot mode powers the analog section up, lets it settle, converts once and powers it down again. Standby keeps the converter off. All timing is counted in system clocks, so the settling time, the output period and the guard window are parameters.

The serial front end drives the block with three strobes: a mode-field write, a channel change and the end of a result-register read. In return it sees a ready flag that is active high while no fresh result is waiting, and an error flag that marks a clamped result. The modulator side gets a power request and a conversion-start marker. It supplies the raw result and a clamp indication, and the block latches both on its load strobe. The ready flag goes high a fixed number of cycles before every load, so that a read cannot start while the register is about to change. After any restart the first result takes two output periods, because the filter has to settle again.

Top module: `conv_seq`

## Requirements
- R1: After reset the block is in continuous mode with `pwr_req`=1, `rdy`=1, `err`=0 and `data_q`=0. The cycle right after reset is the first cycle of a conversion, so `conv_start`=1 in that cycle.
- R2: The 2-bit `mode` field is captured when `mode_wr` is high. 2'b00 selects continuous, 2'b10 selects single-shot, and 2'b01 or 2'b11 selects standby. `mode_wr` takes priority over `chan_chg`.
- R3: In continuous mode the first load comes 2*PERIOD cycles after reset or after a restart, and later loads come every PERIOD cycles. `conv_start` is high in the first cycle of each conversion, and `data_load` is high in the cycle before each load edge.
- R4: On a load edge, `data_q` takes `mod_result`, `err` takes `mod_clamp` and `rdy` goes low, all on the same edge.
- R5: `rdy` goes high GUARD cycles before every load, and `data_q` changes only on load edges.
- R6: A `rd_done` pulse sets `rdy` on the next edge and leaves `data_q` unchanged. On a load edge the load wins and `rdy` goes low.
- R7: A single-shot write holds `pwr_req` high for PWRUP cycles and then converts for 2*PERIOD cycles. After the load, `pwr_req` drops. `rdy` then stays low and `data_q` is held until a read or a restart.
- R8: A write that selects standby drops `pwr_req`, sets `rdy`, and stops all loads, so `data_q` keeps its value.
- R9: A mode write, or a channel change while powered, restarts conversion timing and sets `rdy`. A channel change while powered down is ignored.
- R10: A mode write that selects continuous or single-shot clears `err`. A channel change leaves `err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating-mode field, sampled on `mode_wr` |
| mode_wr | input | 1 | Mode-field write strobe |
| chan_chg | input | 1 | Channel-change strobe |
| rd_done | input | 1 | Result-register read finished |
| mod_result | input | W | Raw result from the modulator and filter |
| mod_clamp | input | 1 | Raw result was clamped to all zeros or all ones |
| pwr_req | output | 1 | Analog section power request |
| conv_start | output | 1 | First cycle of a conversion |
| data_load | output | 1 | Result register loads on the coming edge |
| rdy | output | 1 | High while no unread fresh result is waiting |
| err | output | 1 | Latest result was clamped |
| data_q | output | W | Result register |

## Verification
A wrong count or a stale first-conversion flag moves `data_load` and the fall of `rdy` by whole cycles. The bench compares these against the expected period grid on every cycle, so such an error shows at the first load after a restart, within 2*PERIOD cycles. A wrong priority between read, load and restart shows in the very next cycle as a `rdy` level that disagrees with the bench model. A wrong mode decode shows at once on `pwr_req`, or as a load that arrives or fails to arrive at the expected edge.

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int W      = 24,
  parameter int PERIOD = 1000,
  parameter int PWRUP  = 200,
  parameter int GUARD  = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         mode_wr,
  input  logic         chan_chg,
  input  logic         rd_done,
  input  logic [W-1:0] mod_result,
  input  logic         mod_clamp,
  output logic         pwr_req,
  output logic         conv_start,
  output logic         data_load,
  output logic         rdy,
  output logic         err,
  output logic [W-1:0] data_q
);
  localparam int CW = $clog2(2*PERIOD + PWRUP + 1);
  localparam logic [1:0] M_CONT = 2'b00;
  localparam logic [1:0] M_SING = 2'b10;

  typedef enum logic [1:0] {S_OFF, S_PWR, S_CONV} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          first;
  logic [1:0]    mreg;
  logic [CW-1:0] tgt;

  assign tgt        = first ? CW'(2*PERIOD-1) : CW'(PERIOD-1);
  assign data_load  = (st == S_CONV) && (cnt == tgt);
  assign conv_start = (st == S_CONV) && (cnt == '0);
  assign pwr_req    = (st != S_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_CONV; cnt <= '0; first <= 1'b1; mreg <= M_CONT;
      rdy <= 1'b1; err <= 1'b0; data_q <= '0;
    end else if (mode_wr) begin
      mreg <= mode; rdy <= 1'b1; cnt <= '0; first <= 1'b1;
      if (mode == M_CONT) begin
        st <= S_CONV; err <= 1'b0;
      end else if (mode == M_SING) begin
        st <= S_PWR; err <= 1'b0;
      end else begin
        st <= S_OFF;
      end
    end else if (chan_chg && st != S_OFF) begin
      rdy <= 1'b1; cnt <= '0; first <= 1'b1;
      st <= (mreg == M_SING) ? S_PWR : S_CONV;
    end else begin
      case (st)
        S_PWR: begin
          if (cnt == CW'(PWRUP-1)) begin
            st <= S_CONV; cnt <= '0; first <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
          if (rd_done) rdy <= 1'b1;
        end
        S_CONV: begin
          if (data_load) begin
            data_q <= mod_result; err <= mod_clamp; rdy <= 1'b0;
            cnt <= '0; first <= 1'b0;
            if (mreg == M_SING) st <= S_OFF;
          end else begin
            cnt <= cnt + 1'b1;
            if (rd_done || cnt == tgt - CW'(GUARD)) rdy <= 1'b1;
          end
        end
        default: if (rd_done) rdy <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(parameter int W = 24) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         mode_wr,
  input logic         chan_chg,
  input logic         rd_done,
  input logic         pwr_req,
  input logic         conv_start,
  input logic         data_load,
  input logic         rdy,
  input logic         err,
  input logic [W-1:0] data_q
);
  p_load_clears_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_load && !mode_wr && !chan_chg |=> !rdy);
  p_guard_before_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_load |-> rdy);
  p_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_load |=> $stable(data_q));
  p_read_sets_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !data_load |=> rdy);
  p_start_powered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> pwr_req);
  p_off_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_req |-> !data_load);
  p_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && mode[0] |=> !pwr_req && rdy);
  p_chan_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_chg && !mode_wr && !pwr_req |=> !pwr_req);
  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && !mode[0] |=> !err);
endmodule

bind conv_seq conv_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mode_wr(mode_wr), .chan_chg(chan_chg),
  .rd_done(rd_done), .pwr_req(pwr_req), .conv_start(conv_start),
  .data_load(data_load), .rdy(rdy), .err(err), .data_q(data_q)
);

// File: tb/conv_seq_bench.sv
module conv_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, P = 20, PU = 7, G = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic mode_wr = 0, chan_chg = 0, rd_done = 0, mod_clamp = 0;
  logic [W-1:0] mod_result = 0;
  logic pwr_req, conv_start, data_load, rdy, err;
  logic [W-1:0] data_q;

  int checks = 0, failures = 0;
  logic [W-1:0] exp_data;
  logic exp_err;
  bit rd_after;
  bit done = 0;

  conv_seq #(.W(W), .PERIOD(P), .PWRUP(PU), .GUARD(G)) u_conv_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mode_wr(mode_wr), .chan_chg(chan_chg),
    .rd_done(rd_done), .mod_result(mod_result), .mod_clamp(mod_clamp),
    .pwr_req(pwr_req), .conv_start(conv_start), .data_load(data_load),
    .rdy(rdy), .err(err), .data_q(data_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_load(int k);
    return (k >= 2*P) && ((k - 2*P) % P == 0);
  endfunction

  function automatic int next_load(int k);
    if (k < 2*P) return 2*P;
    return 2*P + ((k - 2*P)/P + 1)*P;
  endfunction

  task automatic run_cont(int n, int fc, int frd);
    for (int k = 0; k < n; k++) begin
      chk("R3 data_load", data_load, is_load(k+1));
      chk("R3 conv_start", conv_start, (k == 0) || is_load(k));
      chk("R5 data_q held", data_q, exp_data);
      if (is_load(k)) begin
        chk("R4 rdy low after load", rdy, 0);
        chk("R4 err from clamp", err, exp_err);
        rd_after = 0;
      end else begin
        chk("R5/R6 rdy", rdy, (k < 2*P) || (next_load(k) - k <= G) || rd_after);
      end
      mod_result = W'($urandom);
      mod_clamp  = ($urandom % 2 == 1) || (k+1 == fc);
      rd_done    = ($urandom % 6 == 0) || (k+1 == frd);
      if (is_load(k+1)) begin
        exp_data = mod_result; exp_err = mod_clamp;
      end else if (rd_done) rd_after = 1;
      @(negedge clk);
    end
    rd_done = 0;
  endtask

  task automatic strobe_mode(logic [1:0] m);
    mode = m; mode_wr = 1;
    @(negedge clk);
    mode_wr = 0;
  endtask

  task automatic strobe_chan();
    chan_chg = 1;
    @(negedge clk);
    chan_chg = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 rdy", rdy, 1);
    chk("R1 err", err, 0);
    chk("R1 data_q", data_q, 0);
    chk("R1 pwr_req", pwr_req, 1);
    chk("R1 conv_start", conv_start, 1);
    exp_data = 0; exp_err = 0; rd_after = 0;
    run_cont(6*P, 6*P, 3*P);

    strobe_chan();
    chk("R10 err kept on channel change", err, 1);
    chk("R9 rdy set on restart", rdy, 1);
    rd_after = 0;
    run_cont(4*P, 0, 0);

    strobe_mode(2'b00);
    chk("R10 err cleared by mode write", err, 0);
    exp_err = 0; rd_after = 0;
    run_cont(3*P, 0, 0);

    strobe_mode(2'b10);
    chk("R10 err cleared by single write", err, 0);
    mod_result = 16'hA5C3; mod_clamp = 1;
    for (int k = 0; k < PU + 2*P; k++) begin
      chk("R7 pwr_req during single", pwr_req, 1);
      chk("R7 conv_start after power-up", conv_start, k == PU);
      chk("R7 data_load timing", data_load, k == PU + 2*P - 1);
      @(negedge clk);
    end
    chk("R7 data_q loaded", data_q, 16'hA5C3);
    chk("R7 rdy low", rdy, 0);
    chk("R7 powered down", pwr_req, 0);
    chk("R4 err from clamp single", err, 1);
    mod_result = 16'h1111; mod_clamp = 0;
    strobe_chan();
    seen = 0;
    for (int k = 0; k < 3*P; k++) begin
      if (data_load || pwr_req || rdy) seen = 1;
      @(negedge clk);
    end
    chk("R9 channel change ignored off", seen, 0);
    chk("R7 data held", data_q, 16'hA5C3);
    rd_done = 1;
    @(negedge clk);
    rd_done = 0;
    chk("R6 read sets rdy", rdy, 1);
    chk("R6 read keeps data", data_q, 16'hA5C3);

    strobe_mode(2'b00);
    exp_data = 16'hA5C3; exp_err = 0; rd_after = 0;
    run_cont(3*P, 0, 0);
    strobe_mode(2'b01);
    chk("R8 standby pwr_req", pwr_req, 0);
    chk("R8 standby rdy", rdy, 1);
    seen = 0;
    for (int k = 0; k < 3*P; k++) begin
      mod_result = W'($urandom);
      if (data_load || pwr_req) seen = 1;
      @(negedge clk);
    end
    chk("R8 no load in standby", seen, 0);
    chk("R8 data held in standby", data_q, exp_data);
    strobe_mode(2'b11);
    chk("R2 code 11 is standby", pwr_req, 0);
    strobe_mode(2'b00);
    chk("R2 code 00 is continuous", pwr_req, 1);
    rd_after = 0;
    run_cont(3*P, 3*P, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule